// File: doc/BRIEF.md
# GPIO Pad Configuration Register Bank

This block is a slave register file that owns the configuration and drive state of a bank of general-purpose pads, up to 64 of them. Software reaches it over a plain 32-bit bus made of a byte address, a write strobe, write data and registered read data. Each pad gets its own 16-byte window holding four 32-bit words: two configuration words, a value word and a spare default word. The pad index multiplied by 16 gives the window's base address.

The value word carries the pad level in bit 0, an active-low output enable in bit 1 and an active-low input enable in bit 2. The block turns these into the pad's output level, output enable and input enable. It samples each pad's input through a two-flop synchronizer so that software can read it. Configuration word 0 supplies each pad's 3-bit function select, its open-drain enable and its debounce enable as outputs. The pull and other analog fields are storage only. Edge and level interrupt detection belongs to a separate block that reads these outputs.

To make a pad an input, software first sets both enable bits and then clears bit 2. To make it an output, software clears bits 1 and 2 and writes the level in that same write.

Top module: `gpio_pad_bank`

## Requirements
- R1: After reset every value word reads 0x6 (both enables set, level 0), every configuration word and default word reads 0, and pad_oe and pad_ie are 0 for every pad.
- R2: Pad p's window starts at byte address 16*p. Offset 0x0 is configuration word 0, 0x4 is configuration word 1, 0x8 is the value word and 0xC is the default word. Configuration words 0 and 1 and the default word store all 32 written bits and read them back unchanged.
- R3: The value word keeps only bits 2:0. Bits 31:3 always read as zero.
- R4: pad_oe[p] is the inverse of value bit 1 and pad_ie[p] is the inverse of value bit 2. When open drain is off, pad_out[p] equals value bit 0.
- R5: pad_func[3p+2:3p] equals bits 2:0 of pad p's configuration word 0.
- R6: When bit 31 of configuration word 0 (open drain) is set, pad_out[p] is 0. pad_oe[p] is 1 only when value bit 1 is 0 and the level bit is 0, so the pad is released for level 1.
- R7: pad_od_en[p] equals bit 31 and pad_deb_en[p] equals bit 20 of pad p's configuration word 0.
- R8: With value bit 2 at 0, bit 0 of a value-word read returns pad_in[p] after a two-flop synchronizer. A change on pad_in appears in bus_rdata three clock edges later when the address is held. With bit 2 at 1, bit 0 returns the stored level.
- R9: An address whose pad index is not below NUM_PADS, or whose two low bits are not zero, reads as zero. A write to such an address changes no register and no output.
- R10: bus_rdata is registered. It shows the word addressed in the previous cycle.
- R11: A write changes only the addressed word of the addressed pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | BUS_AW | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PADS | Sampled pad levels (asynchronous) |
| pad_out | output | NUM_PADS | Pad output levels |
| pad_oe | output | NUM_PADS | Pad output enables, active high |
| pad_ie | output | NUM_PADS | Pad input enables, active high |
| pad_func | output | 3*NUM_PADS | Per-pad function select, 3 bits each |
| pad_od_en | output | NUM_PADS | Per-pad open-drain enable |
| pad_deb_en | output | NUM_PADS | Per-pad debounce enable |

## Verification
The properties assume that bus_addr, bus_we and bus_wdata are stable around each rising edge. They also assume that the upper address bits above BUS_AW do not exist, so every address in the BUS_AW range is either a mapped word or an unmapped one. The bench drives every bus input at the falling edge and samples at the next falling edge, which keeps the stimulus within these assumptions. pad_in is the only asynchronous input, and it too changes only at falling edges, so the synchronizer latency the bench expects is exact rather than off by one cycle. The sweep writes a distinct pattern to every word of every pad and covers all eight value encodings and both open-drain settings. It then reads every word back, which checks both the stored data and the isolation between pads.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Word slot within a pad window: byte offset = slot * 4
    typedef enum logic [1:0] {
        SLOT_CFG0  = 2'd0,
        SLOT_CFG1  = 2'd1,
        SLOT_VALUE = 2'd2,
        SLOT_DFLT  = 2'd3
    } slot_e;

    localparam int WORD_W    = 32;
    localparam int FUNC_W    = 3;
    localparam int VAL_W     = 3;
    localparam int LVL_BIT   = 0;
    localparam int OEN_BIT   = 1;
    localparam int IEN_BIT   = 2;
    localparam int DEB_BIT   = 20;
    localparam int OD_BIT    = 31;
    localparam int WIN_SHIFT = 4;   // 16-byte window per pad

    localparam logic [VAL_W-1:0] VALUE_RST = 3'b110;

    typedef struct packed {
        logic [WORD_W-1:0] cfg0;
        logic [WORD_W-1:0] cfg1;
        logic [WORD_W-1:0] dflt;
        logic [VAL_W-1:0]  value;
    } pad_regs_t;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PADS  = 8,
    parameter int BUS_AW    = 12,
    parameter int PAD_IDX_W = 3
) (
    input  logic [BUS_AW-1:0]    addr,
    output logic                 hit,
    output logic [PAD_IDX_W-1:0] pad_idx,
    output slot_e                slot
);
    localparam int FIELD_W = BUS_AW - WIN_SHIFT;
    localparam logic [FIELD_W-1:0] PAD_LIMIT = FIELD_W'(NUM_PADS);

    logic [FIELD_W-1:0] field;

    always_comb begin
        field   = addr[BUS_AW-1:WIN_SHIFT];
        pad_idx = field[PAD_IDX_W-1:0];
        slot    = slot_e'(addr[WIN_SHIFT-1:2]);
        hit     = (addr[1:0] == 2'b00) && (field < PAD_LIMIT);
    end
endmodule

// File: rtl/gpio_pad_regs.sv
module gpio_pad_regs
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  slot_e             slot,
    input  logic [WORD_W-1:0] wdata,
    output pad_regs_t         regs
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs.cfg0  <= '0;
            regs.cfg1  <= '0;
            regs.dflt  <= '0;
            regs.value <= VALUE_RST;
        end else if (wr_en) begin
            unique case (slot)
                SLOT_CFG0:  regs.cfg0  <= wdata;
                SLOT_CFG1:  regs.cfg1  <= wdata;
                SLOT_VALUE: regs.value <= wdata[VAL_W-1:0];
                SLOT_DFLT:  regs.dflt  <= wdata;
            endcase
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            sync_out <= '0;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
    import gpio_bank_pkg::*;
(
    input  pad_regs_t         regs,
    output logic              drv_level,
    output logic              drv_oe,
    output logic              drv_ie,
    output logic [FUNC_W-1:0] drv_func,
    output logic              drv_od,
    output logic              drv_deb
);
    logic level, out_on;

    always_comb begin
        level     = regs.value[LVL_BIT];
        out_on    = !regs.value[OEN_BIT];
        drv_od    = regs.cfg0[OD_BIT];
        drv_deb   = regs.cfg0[DEB_BIT];
        drv_func  = regs.cfg0[FUNC_W-1:0];
        drv_ie    = !regs.value[IEN_BIT];
        if (drv_od) begin
            // open drain: only ever pulls low, releases for a high level
            drv_level = 1'b0;
            drv_oe    = out_on && !level;
        end else begin
            drv_level = level;
            drv_oe    = out_on;
        end
    end
endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PADS = 8,
    parameter int BUS_AW   = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [BUS_AW-1:0]          bus_addr,
    input  logic                       bus_we,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    input  logic [NUM_PADS-1:0]        pad_in,
    output logic [NUM_PADS-1:0]        pad_out,
    output logic [NUM_PADS-1:0]        pad_oe,
    output logic [NUM_PADS-1:0]        pad_ie,
    output logic [3*NUM_PADS-1:0]      pad_func,
    output logic [NUM_PADS-1:0]        pad_od_en,
    output logic [NUM_PADS-1:0]        pad_deb_en
);
    localparam int PAD_IDX_W = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;

    logic                 dec_hit;
    logic [PAD_IDX_W-1:0] dec_idx;
    slot_e                dec_slot;
    pad_regs_t            regs [NUM_PADS];
    logic [NUM_PADS-1:0]  pad_sync;
    logic [WORD_W-1:0]    rd_next;

    gpio_addr_decode #(
        .NUM_PADS (NUM_PADS),
        .BUS_AW   (BUS_AW),
        .PAD_IDX_W(PAD_IDX_W)
    ) u_decode (
        .addr   (bus_addr),
        .hit    (dec_hit),
        .pad_idx(dec_idx),
        .slot   (dec_slot)
    );

    gpio_in_sync #(.WIDTH(NUM_PADS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(pad_in),
        .sync_out(pad_sync)
    );

    for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
        logic wr_sel;
        assign wr_sel = bus_we && dec_hit && (dec_idx == PAD_IDX_W'(g));

        gpio_pad_regs u_regs (
            .clk  (clk),
            .rst_n(rst_n),
            .wr_en(wr_sel),
            .slot (dec_slot),
            .wdata(bus_wdata),
            .regs (regs[g])
        );

        gpio_pad_drive u_drive (
            .regs     (regs[g]),
            .drv_level(pad_out[g]),
            .drv_oe   (pad_oe[g]),
            .drv_ie   (pad_ie[g]),
            .drv_func (pad_func[FUNC_W*g +: FUNC_W]),
            .drv_od   (pad_od_en[g]),
            .drv_deb  (pad_deb_en[g])
        );
    end

    always_comb begin
        rd_next = '0;
        if (dec_hit) begin
            unique case (dec_slot)
                SLOT_CFG0:  rd_next = regs[dec_idx].cfg0;
                SLOT_CFG1:  rd_next = regs[dec_idx].cfg1;
                SLOT_DFLT:  rd_next = regs[dec_idx].dflt;
                SLOT_VALUE: rd_next = {{(WORD_W-VAL_W){1'b0}},
                                       regs[dec_idx].value[IEN_BIT:OEN_BIT],
                                       regs[dec_idx].value[IEN_BIT] ?
                                           regs[dec_idx].value[LVL_BIT] :
                                           pad_sync[dec_idx]};
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_next;
    end
endmodule

// File: rtl/gpio_pad_bank_chk.sv
module gpio_pad_bank_chk #(
    parameter int NUM_PADS = 8,
    parameter int BUS_AW   = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [BUS_AW-1:0]     bus_addr,
    input logic                  bus_we,
    input logic [31:0]           bus_wdata,
    input logic [31:0]           bus_rdata,
    input logic [NUM_PADS-1:0]   pad_out,
    input logic [NUM_PADS-1:0]   pad_oe,
    input logic [NUM_PADS-1:0]   pad_ie,
    input logic [3*NUM_PADS-1:0] pad_func,
    input logic [NUM_PADS-1:0]   pad_od_en,
    input logic [NUM_PADS-1:0]   pad_deb_en
);
    localparam int FW = BUS_AW - 4;
    localparam logic [FW-1:0] LIMIT = FW'(NUM_PADS);

    logic unmapped, val_rd, wr_p0_val, wr_p0_cfg0;
    assign unmapped   = (bus_addr[1:0] != 2'b00) || (bus_addr[BUS_AW-1:4] >= LIMIT);
    assign val_rd     = !unmapped && (bus_addr[3:2] == 2'd2);
    assign wr_p0_val  = bus_we && (bus_addr == BUS_AW'(8));
    assign wr_p0_cfg0 = bus_we && (bus_addr == BUS_AW'(0));

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && pad_ie == '0));

    p_value_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        val_rd |=> (bus_rdata[31:3] == '0));

    p_ie_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_p0_val |=> (pad_ie[0] == !$past(bus_wdata[2])));

    p_func_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_p0_cfg0 |=> (pad_func[2:0] == $past(bus_wdata[2:0])));

    p_deb_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_p0_cfg0 |=> (pad_deb_en[0] == $past(bus_wdata[20])));

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |=> (bus_rdata == '0));

    for (genvar i = 0; i < NUM_PADS; i++) begin : g_od
        p_od_never_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (pad_od_en[i] && pad_oe[i]) |-> !pad_out[i]);
    end
endmodule

bind gpio_pad_bank gpio_pad_bank_chk #(
    .NUM_PADS(NUM_PADS),
    .BUS_AW  (BUS_AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_ie    (pad_ie),
    .pad_func  (pad_func),
    .pad_od_en (pad_od_en),
    .pad_deb_en(pad_deb_en)
);

// File: tb/gpio_pad_bank_tb.sv
`timescale 1ns/1ps
module gpio_pad_bank_tb;
    localparam int NP = 8;
    localparam int AW = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NP-1:0]   pad_in = '0;
    logic [NP-1:0]   pad_out, pad_oe, pad_ie, pad_od_en, pad_deb_en;
    logic [3*NP-1:0] pad_func;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gpio_pad_bank #(.NUM_PADS(NP), .BUS_AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie),
        .pad_func(pad_func), .pad_od_en(pad_od_en), .pad_deb_en(pad_deb_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    function automatic logic [31:0] cfg_pat(input int p);
        logic [31:0] v;
        v = 32'h0012_3450 * (p + 3);
        v[31] = p[0];
        v[20] = p[1];
        v[2:0] = 3'(p) ^ 3'd3;
        return v;
    endfunction

    function automatic logic [2:0] val_pat(input int p);
        return 3'((p * 5 + 1) % 8);
    endfunction

    function automatic logic [AW-1:0] adr(input int p, input int off);
        return AW'(p * 16 + off);
    endfunction

    initial begin
        logic [31:0] rd;
        logic [2:0]  v;
        logic [31:0] c;
        logic        od, e_oe, e_out, old_in;
        pad_in = 8'hA5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 oe", 32'(pad_oe), 32'h0);
        check("R1 ie", 32'(pad_ie), 32'h0);
        for (int p = 0; p < NP; p++) begin
            bus_read(adr(p, 8), rd);  check("R1 value", rd, 32'h6);
            bus_read(adr(p, 0), rd);  check("R1 cfg0", rd, 32'h0);
            bus_read(adr(p, 12), rd); check("R1 dflt", rd, 32'h0);
        end

        // R2/R11: sweep distinct patterns into every word of every pad
        for (int p = 0; p < NP; p++) begin
            bus_write(adr(p, 0), cfg_pat(p));
            bus_write(adr(p, 4), ~cfg_pat(p));
            bus_write(adr(p, 12), cfg_pat(p) + 32'd7);
            bus_write(adr(p, 8), 32'hFFFF_FFF8 | 32'(val_pat(p)));
        end
        repeat (3) @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            c = cfg_pat(p); v = val_pat(p); od = c[31];
            bus_read(adr(p, 0), rd);  check("R2 R11 cfg0", rd, c);
            bus_read(adr(p, 4), rd);  check("R2 R11 cfg1", rd, ~c);
            bus_read(adr(p, 12), rd); check("R2 R11 dflt", rd, c + 32'd7);
            bus_read(adr(p, 8), rd);
            // R3/R8: upper bits zero; bit0 from synchronized input when input enabled
            check("R3 R8 value", rd, {29'd0, v[2:1], v[2] ? v[0] : pad_in[p]});
            e_oe  = !v[1] && !(od && v[0]);
            e_out = od ? 1'b0 : v[0];
            check(od ? "R6 oe" : "R4 oe", 32'(pad_oe[p]), 32'(e_oe));
            check(od ? "R6 out" : "R4 out", 32'(pad_out[p]), 32'(e_out));
            check("R4 ie", 32'(pad_ie[p]), 32'(!v[2]));
            check("R5 func", 32'(pad_func[3*p +: 3]), 32'(c[2:0]));
            check("R7 od", 32'(pad_od_en[p]), 32'(c[31]));
            check("R7 deb", 32'(pad_deb_en[p]), 32'(c[20]));
        end

        // R6: open-drain pad 1, output enabled, level 0 then 1
        bus_write(adr(1, 8), 32'h0);
        check("R6 od low drives", {30'd0, pad_oe[1], pad_out[1]}, 32'h2);
        bus_write(adr(1, 8), 32'h1);
        check("R6 od high releases", {30'd0, pad_oe[1], pad_out[1]}, 32'h0);

        // R8/R10: synchronizer latency on pad 3 configured as input
        bus_write(adr(3, 8), 32'h6);
        bus_write(adr(3, 8), 32'h3);
        repeat (3) @(negedge clk);
        old_in = pad_in[3];
        @(negedge clk);
        bus_addr = adr(3, 8);
        pad_in[3] = ~old_in;
        @(negedge clk); check("R8 R10 edge1", bus_rdata, {30'd1, old_in});
        @(negedge clk); check("R8 edge2", bus_rdata, {30'd1, old_in});
        @(negedge clk); check("R8 edge3", bus_rdata, {30'd1, ~old_in});
        // R8: input disabled returns stored level (1), not pad_in
        bus_write(adr(3, 8), 32'h7);
        pad_in[3] = 1'b0;
        repeat (3) @(negedge clk);
        bus_read(adr(3, 8), rd); check("R8 stored level", rd, 32'h7);

        // R9: unmapped reads and writes
        bus_write(adr(0, 8), 32'h2);
        bus_write(AW'(NP * 16 + 8), 32'h5);
        bus_write(AW'(9), 32'h5);
        bus_write(AW'(2), 32'h0000_0007);
        bus_read(adr(0, 8), rd);  check("R9 value kept", rd, {29'd0, 2'b01, pad_in[0]});
        check("R9 ie kept", 32'(pad_ie[0]), 32'h1);
        bus_read(adr(0, 0), rd);  check("R9 cfg0 kept", rd, cfg_pat(0));
        check("R9 func kept", 32'(pad_func[2:0]), 32'(cfg_pat(0) & 32'h7));
        bus_read(AW'(NP * 16), rd); check("R9 read beyond", rd, 32'h0);
        bus_read(AW'(9), rd);       check("R9 read misaligned", rd, 32'h0);
        bus_read(AW'(4095), rd);    check("R9 read top", rd, 32'h0);

        // R10: read data follows address change by one cycle
        @(negedge clk); bus_addr = adr(2, 0);
        @(negedge clk); check("R10 first", bus_rdata, cfg_pat(2));
        bus_addr = adr(2, 4);
        check("R10 held", bus_rdata, cfg_pat(2));
        @(negedge clk); check("R10 next", bus_rdata, ~cfg_pat(2));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule